// File: doc/BRIEF.md
# Synchronous FIFO drain waveform engine

This block empties an external synchronous FIFO into a downstream sink. A host processor starts it with a one-cycle trigger. It then holds the FIFO's active-low read strobe and active-low output enable low without a break, and it hands one word per clock to the sink. The block's clock is also the read clock of the FIFO. At 48 MHz a 4096-word FIFO empties in about 85.3 µs. When the FIFO runs empty the engine goes back to idle and raises a done flag, which the processor polls.

The sequencer runs three states: idle, loop and data. The loop state is the only one that branches, and it tests the active-low empty flag only on the clock edge that enters it. A high flag means go on to the data state; a low flag means return to idle. The data state always goes back to the loop state. So the flag is tested again on every second clock while both enables stay low. The flag value latched on entry decides the branch, whatever the flag does while the engine is in that state. A word counts as taken on each rising edge where the read strobe is low and the empty flag is high. A registered valid and data pair passes that word to the sink.

Top module: `fifo_drain_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `done_o` is 1, `fifo_rd_n_o` and `fifo_oe_n_o` are 1 and `snk_valid_o` is 0.
- R2: A `start_i` pulse sampled while idle (`done_o`=1) makes `fifo_rd_n_o`=0, `fifo_oe_n_o`=0 and `done_o`=0 right after that edge. This edge is the first entry into the loop state.
- R3: From the start edge until the return to idle, `fifo_rd_n_o` and `fifo_oe_n_o` stay low on every cycle, with no toggling.
- R4: After each edge where `fifo_rd_n_o`=0 and `fifo_empty_n_i`=1, `snk_valid_o` is 1 for one cycle and `snk_data_o` equals `fifo_data_i` as sampled at that edge. With N words present, the words arrive on the N cycles that follow the start edge, one per clock and in FIFO order.
- R5: The loop state is entered at the start edge and again every second edge after it. Its branch uses only the empty flag sampled at the entering edge.
- R6: The engine returns to idle one edge after the first loop-state entry that samples `fifo_empty_n_i`=0. On that edge `done_o` goes to 1 and both enables go to 1.
- R7: If the FIFO is already empty at the start edge, `snk_valid_o` stays 0 and `done_o` is 1 again after one edge.
- R8: A `start_i` pulse while busy has no effect on the word stream, the enables or the done timing.
- R9: Once set, `done_o` stays 1 until the next accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, also the FIFO read clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse from the host processor |
| fifo_empty_n_i | input | 1 | FIFO empty flag, active low (1 = words available) |
| fifo_data_i | input | DATA_W | FIFO read data |
| fifo_rd_n_o | output | 1 | FIFO read strobe, active low |
| fifo_oe_n_o | output | 1 | FIFO output enable, active low |
| snk_data_o | output | DATA_W | Word passed to the sink |
| snk_valid_o | output | 1 | High for one cycle per word taken |
| done_o | output | 1 | Done flag for polling, high while idle |

## Verification
The enables and the done flag change right after the start edge. Word k (counting from 1) shows up after the k-th edge following it. `done_o` rises one edge after the first even-numbered edge at or after N+1 (N>0), or after edge 1 when N is 0. The bench computes this edge from the word count before each run. It then samples every output at the falling edge after each rising edge, and compares valid, data, enables and done on every cycle until two cycles past the expected idle edge. A start pulse placed in mid-run must leave those same per-cycle expectations unchanged.

// File: rtl/fde_pkg.sv
package fde_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_DATA = 2'd2
  } fde_state_t;
endpackage

// File: rtl/fde_seq.sv
// Waveform sequencer: the loop state branches on the flag captured at entry.
module fde_seq
  import fde_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       empty_n_i,
  output fde_state_t nxt_o
);
  fde_state_t state_q;
  fde_state_t nxt;
  logic       cont_q;   // branch decision latched when the loop state is entered

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_IDLE: if (start_i) nxt = ST_LOOP;
      ST_LOOP: nxt = cont_q ? ST_DATA : ST_IDLE;
      ST_DATA: nxt = ST_LOOP;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cont_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      // loop is never re-entered from itself, so nxt==LOOP marks an entry edge
      if (nxt == ST_LOOP) cont_q <= empty_n_i;
    end
  end

  assign nxt_o = nxt;
endmodule

// File: rtl/fde_strobe.sv
// Registered strobes and done flag, derived from the next state.
module fde_strobe
  import fde_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  fde_state_t nxt_i,
  output logic       rd_n_o,
  output logic       oe_n_o,
  output logic       done_o
);
  logic idle_nxt;
  assign idle_nxt = (nxt_i == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n_o <= 1'b1;
      oe_n_o <= 1'b1;
      done_o <= 1'b1;
    end else begin
      rd_n_o <= idle_nxt;
      oe_n_o <= idle_nxt;
      done_o <= idle_nxt;
    end
  end
endmodule

// File: rtl/fde_capture.sv
// Takes a word on each edge where the read strobe is low and the FIFO is not empty.
module fde_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n_i,
  input  logic              empty_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic take;
  assign take = !rd_n_i && empty_n_i;

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= take;
  end

  always_ff @(posedge clk) begin
    if (rst)       data_o <= '0;
    else if (take) data_o <= data_i;
  end
endmodule

// File: rtl/fifo_drain_engine.sv
module fifo_drain_engine
  import fde_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              fifo_empty_n_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_rd_n_o,
  output logic              fifo_oe_n_o,
  output logic [DATA_W-1:0] snk_data_o,
  output logic              snk_valid_o,
  output logic              done_o
);
  fde_state_t nxt;

  fde_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .empty_n_i (fifo_empty_n_i),
    .nxt_o     (nxt)
  );

  fde_strobe u_strobe (
    .clk    (clk),
    .rst    (rst),
    .nxt_i  (nxt),
    .rd_n_o (fifo_rd_n_o),
    .oe_n_o (fifo_oe_n_o),
    .done_o (done_o)
  );

  fde_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .rd_n_i    (fifo_rd_n_o),
    .empty_n_i (fifo_empty_n_i),
    .data_i    (fifo_data_i),
    .data_o    (snk_data_o),
    .valid_o   (snk_valid_o)
  );
endmodule

// File: rtl/fde_checker.sv
module fde_checker (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic fifo_empty_n_i,
  input logic fifo_rd_n_o,
  input logic fifo_oe_n_o,
  input logic snk_valid_o,
  input logic done_o
);
  // R2: accepted start drops both enables and clears done
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> (!fifo_rd_n_o && !fifo_oe_n_o && !done_o));

  // R4: a word is delivered only after an edge that really read one
  p_valid_src_r4: assert property (@(posedge clk) disable iff (rst)
    snk_valid_o |-> ($past(!fifo_rd_n_o) && $past(fifo_empty_n_i)));

  // R8: the read strobe only falls as a result of a start request
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_rd_n_o) |-> $past(start_i));

  // R9: done holds while no start arrives
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  // R6: two consecutive low flag samples cover a loop entry, so idle follows
  p_empty_exit_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!fifo_empty_n_i, 3) && $past(!fifo_empty_n_i, 2) && !$past(start_i)) |-> done_o);

  // R3: enables stay low together while busy
  p_enables_busy_r3: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (!fifo_rd_n_o && !fifo_oe_n_o));
endmodule

bind fifo_drain_engine fde_checker u_fde_chk (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .fifo_empty_n_i (fifo_empty_n_i),
  .fifo_rd_n_o    (fifo_rd_n_o),
  .fifo_oe_n_o    (fifo_oe_n_o),
  .snk_valid_o    (snk_valid_o),
  .done_o         (done_o)
);

// File: tb/fifo_drain_engine_bench.sv
module fifo_drain_engine_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          empty_n;
  logic [DW-1:0] fdata;
  logic          rd_n, oe_n, valid, done;
  logic [DW-1:0] sdata;

  // FIFO model state
  logic          load = 1'b0;
  int            load_n = 0;
  int            fcnt = 0;
  int            fptr = 0;
  logic [DW-1:0] fbase = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fifo_drain_engine #(.DATA_W(DW)) u_fifo_drain_engine (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start),
    .fifo_empty_n_i (empty_n),
    .fifo_data_i    (fdata),
    .fifo_rd_n_o    (rd_n),
    .fifo_oe_n_o    (oe_n),
    .snk_data_o     (sdata),
    .snk_valid_o    (valid),
    .done_o         (done)
  );

  assign empty_n = (fcnt > 0);
  assign fdata   = fbase + DW'(fptr);

  always @(posedge clk) begin
    if (load) begin
      fcnt <= load_n;
      fptr <= 0;
    end else if (!rd_n && fcnt > 0) begin
      fcnt <= fcnt - 1;
      fptr <= fptr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R1 done in reset", done, 1);
    chk(rd_n == 1'b1 && oe_n == 1'b1, "R1 enables in reset", {rd_n, oe_n}, 3);
    chk(valid == 1'b0, "R1 valid in reset", valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && rd_n == 1'b1 && valid == 1'b0, "R1 after reset release",
        {done, rd_n, valid}, 6);
  endtask

  // Drain n words; bt>0 places an extra start pulse before edge bt (busy).
  task automatic t_drain(input int n, input int bt, input logic [DW-1:0] base);
    int idle_k;
    int ev;
    fbase  = base;
    load_n = n;
    load   = 1'b1;
    @(negedge clk);
    load   = 1'b0;
    // R5: loop entries at even edges; exit one edge after the first low sample
    if (n == 0) idle_k = 1;
    else begin
      ev = n + 1;
      if (ev % 2 != 0) ev++;
      idle_k = ev + 1;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rd_n == 1'b0 && oe_n == 1'b0, "R2 enables low after start", {rd_n, oe_n}, 0);
    chk(done == 1'b0, "R2 done cleared after start", done, 0);
    for (int k = 1; k <= idle_k + 2; k++) begin
      if (k == bt) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (k <= n) begin
        chk(valid == 1'b1, "R4 word valid", valid, 1);
        chk(sdata == base + DW'(k - 1), "R4 word order", sdata, base + DW'(k - 1));
      end else if (n == 0) begin
        chk(valid == 1'b0, "R7 no word from empty FIFO", valid, 0);
      end else begin
        chk(valid == 1'b0, "R4 no word after drain", valid, 0);
      end
      if (k < idle_k) begin
        chk(rd_n == 1'b0 && oe_n == 1'b0, "R3 enables held low", {rd_n, oe_n}, 0);
        chk(done == 1'b0, "R5 still busy before exit entry", done, 0);
      end else if (k == idle_k) begin
        chk(done == 1'b1, "R6 done at exit edge", done, 1);
        chk(rd_n == 1'b1 && oe_n == 1'b1, "R6 enables released", {rd_n, oe_n}, 3);
      end else begin
        chk(done == 1'b1, "R9 done holds", done, 1);
      end
      if (bt > 0 && k == idle_k)
        chk(done == 1'b1, "R8 busy start did not extend run", done, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_drain(1, 0, 16'h0100);
    t_drain(2, 0, 16'h0200);
    t_drain(5, 0, 16'h0300);
    t_drain(8, 0, 16'h0400);
    t_drain(0, 0, 16'h0500);   // R7
    t_drain(6, 3, 16'h0600);   // R8
    t_drain(7, 2, 16'h0700);   // R8
    t_drain(40, 0, 16'hA000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule